// File: doc/BRIEF.md
# Sync Character Discard Filter

This block sits in a receive path between the character decoder and the write side of a receive buffer. Each valid input character carries a flag that marks it as a sync (fill) character. A two-bit static policy decides which sync characters reach the output:

- **Pass all** (`00`): every character is forwarded.
- **Keep last** (`01`): each run of back-to-back sync characters shrinks to its final member. A lone sync character is kept.
- **Drop sync** (`10` or `11`): every sync character is removed.

Data characters are never removed. Their order is always kept.

In keep-last mode the block cannot know that a sync character ends its run until the next valid character arrives. It therefore parks every character in a one-entry hold stage:

- The next valid input releases the parked character, or
- the next valid input overwrites it, when both are sync characters.

In the other two modes the output follows the input in the same cycle, with no added register. The policy is set while the block is in reset and stays fixed afterwards.

Top module: `sync_discard_filter`

## Requirements
- R1: With policy 00, each cycle with in_valid high gives out_valid high in that same cycle, with out_char equal to in_char and out_is_sync equal to in_is_sync.
- R2: With policy 10 or 11, a valid input with in_is_sync = 1 gives no output. A valid input with in_is_sync = 0 is forwarded unchanged in the same cycle.
- R3: With policy 01, in a run of two or more consecutive valid sync characters, only the last one of the run is forwarded.
- R4: With policy 01, a single sync character between two data characters is forwarded.
- R5: With policy 01, each character leaves in the cycle in which the next valid input is presented, in arrival order. The first valid input after reset produces no output.
- R6: With policy 01, a character held when reset is asserted is discarded and never appears at the output.
- R7: out_valid is never high in a cycle where in_valid is low.
- R8: policy_sel does not change while rst_n is high.
- R9: With policy 01, cycles with in_valid low neither produce output nor disturb the held character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous reset, active low |
| policy_sel | input | 2 | Static discard policy: 00 pass all, 01 keep last of run, 1X drop sync |
| in_valid | input | 1 | Input character strobe |
| in_char | input | CHAR_W | Decoded input character |
| in_is_sync | input | 1 | High when the input character is a sync character |
| out_valid | output | 1 | Output character strobe |
| out_char | output | CHAR_W | Forwarded character |
| out_is_sync | output | 1 | Sync flag of the forwarded character |

## Verification
The checker tests these properties on every cycle:
- no output appears without a valid input;
- pass-all mode forwards every valid character unchanged;
- drop mode never emits a sync character;
- in keep-last mode a forwarded sync character is always followed by a data character, never by another sync character;
- the policy stays fixed outside reset.

Some behaviour can only be shown by the bench's scenarios:
- which member of a run survives;
- that lone sync characters are kept;
- the one-character lag and arrival order;
- that idle gaps leave the held character alone;
- that a held character is lost across reset.

// File: rtl/sdf_pkg.sv
package sdf_pkg;

   typedef enum logic [1:0] {
      MODE_PASS = 2'd0,
      MODE_LAST = 2'd1,
      MODE_DROP = 2'd2
   } sdf_mode_e;

   function automatic sdf_mode_e decode_policy(input logic [1:0] sel);
      if (sel[1])
         return MODE_DROP;
      else if (sel[0])
         return MODE_LAST;
      else
         return MODE_PASS;
   endfunction

endpackage

// File: rtl/sdf_policy_dec.sv
module sdf_policy_dec
   import sdf_pkg::*;
#(
   parameter bit SUPPORT_LAST = 1'b1
) (
   input  logic [1:0] policy_sel,
   output sdf_mode_e  mode
);

   generate
      if (SUPPORT_LAST) begin : g_full
         assign mode = decode_policy(policy_sel);
      end else begin : g_no_last
         // without the hold stage, keep-last degrades to pass-all
         sdf_mode_e raw;
         assign raw  = decode_policy(policy_sel);
         assign mode = (raw == MODE_LAST) ? MODE_PASS : raw;
      end
   endgenerate

endmodule

// File: rtl/sdf_hold_stage.sv
module sdf_hold_stage #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              in_valid,
   input  logic [CHAR_W-1:0] in_char,
   input  logic              in_is_sync,
   output logic              rel_valid,
   output logic [CHAR_W-1:0] rel_char,
   output logic              rel_is_sync
);

   logic              held_v;
   logic [CHAR_W-1:0] held_c;
   logic              held_s;
   logic              supersede;

   // a new sync character overwrites a held sync character
   assign supersede   = held_s && in_is_sync;
   assign rel_valid   = enable && in_valid && held_v && !supersede;
   assign rel_char    = held_c;
   assign rel_is_sync = held_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_v <= 1'b0;
         held_c <= '0;
         held_s <= 1'b0;
      end else if (enable && in_valid) begin
         held_v <= 1'b1;
         held_c <= in_char;
         held_s <= in_is_sync;
      end
   end

endmodule

// File: rtl/sdf_out_mux.sv
module sdf_out_mux
   import sdf_pkg::*;
#(
   parameter int CHAR_W = 8
) (
   input  sdf_mode_e         mode,
   input  logic              in_valid,
   input  logic [CHAR_W-1:0] in_char,
   input  logic              in_is_sync,
   input  logic              rel_valid,
   input  logic [CHAR_W-1:0] rel_char,
   input  logic              rel_is_sync,
   output logic              out_valid,
   output logic [CHAR_W-1:0] out_char,
   output logic              out_is_sync
);

   always_comb begin
      out_valid   = 1'b0;
      out_char    = in_char;
      out_is_sync = in_is_sync;
      unique case (mode)
         MODE_PASS: out_valid = in_valid;
         MODE_DROP: out_valid = in_valid && !in_is_sync;
         MODE_LAST: begin
            out_valid   = rel_valid;
            out_char    = rel_char;
            out_is_sync = rel_is_sync;
         end
         default:   out_valid = 1'b0;
      endcase
   end

endmodule

// File: rtl/sync_discard_filter.sv
module sync_discard_filter
   import sdf_pkg::*;
#(
   parameter int CHAR_W       = 8,
   parameter bit SUPPORT_LAST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        policy_sel,
   input  logic              in_valid,
   input  logic [CHAR_W-1:0] in_char,
   input  logic              in_is_sync,
   output logic              out_valid,
   output logic [CHAR_W-1:0] out_char,
   output logic              out_is_sync
);

   initial begin
      if (CHAR_W < 1)
         $error("sync_discard_filter: CHAR_W must be at least 1");
   end

   sdf_mode_e         mode;
   logic              rel_valid;
   logic [CHAR_W-1:0] rel_char;
   logic              rel_is_sync;

   sdf_policy_dec #(.SUPPORT_LAST(SUPPORT_LAST)) u_dec (
      .policy_sel (policy_sel),
      .mode       (mode)
   );

   generate
      if (SUPPORT_LAST) begin : g_hold
         sdf_hold_stage #(.CHAR_W(CHAR_W)) u_hold (
            .clk         (clk),
            .rst_n       (rst_n),
            .enable      (mode == MODE_LAST),
            .in_valid    (in_valid),
            .in_char     (in_char),
            .in_is_sync  (in_is_sync),
            .rel_valid   (rel_valid),
            .rel_char    (rel_char),
            .rel_is_sync (rel_is_sync)
         );
      end else begin : g_nohold
         assign rel_valid   = 1'b0;
         assign rel_char    = '0;
         assign rel_is_sync = 1'b0;
      end
   endgenerate

   sdf_out_mux #(.CHAR_W(CHAR_W)) u_mux (
      .mode        (mode),
      .in_valid    (in_valid),
      .in_char     (in_char),
      .in_is_sync  (in_is_sync),
      .rel_valid   (rel_valid),
      .rel_char    (rel_char),
      .rel_is_sync (rel_is_sync),
      .out_valid   (out_valid),
      .out_char    (out_char),
      .out_is_sync (out_is_sync)
   );

endmodule

// File: rtl/sdf_checker.sv
module sdf_checker #(
   parameter int CHAR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        policy_sel,
   input logic              in_valid,
   input logic [CHAR_W-1:0] in_char,
   input logic              in_is_sync,
   input logic              out_valid,
   input logic [CHAR_W-1:0] out_char,
   input logic              out_is_sync
);

   // R7
   no_spurious_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> in_valid);

   // R1
   pass_all_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_sel == 2'b00 && in_valid) |->
         (out_valid && out_char == in_char && out_is_sync == in_is_sync));

   // R2
   drop_no_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_sel[1] && out_valid) |-> !out_is_sync);

   // R3
   last_of_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_sel == 2'b01 && out_valid && out_is_sync) |-> !in_is_sync);

   // R8
   policy_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n && $past(rst_n) |-> $stable(policy_sel));

endmodule

bind sync_discard_filter sdf_checker #(.CHAR_W(CHAR_W)) u_sdf_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .policy_sel  (policy_sel),
   .in_valid    (in_valid),
   .in_char     (in_char),
   .in_is_sync  (in_is_sync),
   .out_valid   (out_valid),
   .out_char    (out_char),
   .out_is_sync (out_is_sync)
);

// File: tb/tb_sync_discard_filter.sv
`timescale 1ns/1ps
module tb_sync_discard_filter;

   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    policy_sel = 2'b00;
   logic          in_valid = 1'b0;
   logic [CW-1:0] in_char = '0;
   logic          in_is_sync = 1'b0;
   logic          out_valid;
   logic [CW-1:0] out_char;
   logic          out_is_sync;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;   // 125 MHz

   sync_discard_filter #(.CHAR_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel),
      .in_valid(in_valid), .in_char(in_char), .in_is_sync(in_is_sync),
      .out_valid(out_valid), .out_char(out_char), .out_is_sync(out_is_sync)
   );

   // bench model of the keep-last holding slot
   logic          m_v;
   logic [CW-1:0] m_c;
   logic          m_s;

   task automatic restart(input logic [1:0] pol);
      @(negedge clk);
      rst_n = 1'b0; in_valid = 1'b0; policy_sel = pol;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      m_v = 1'b0; m_c = '0; m_s = 1'b0;
   endtask

   // present one input at negedge, check outputs before the next posedge
   task automatic step(input logic v, input logic [CW-1:0] c, input logic s,
                       input string req);
      logic          ev;
      logic [CW-1:0] ec;
      logic          es;
      @(negedge clk);
      in_valid = v; in_char = c; in_is_sync = s;
      ev = 1'b0; ec = c; es = s;
      if (policy_sel == 2'b00) ev = v;
      else if (policy_sel[1]) ev = v && !s;
      else begin
         ev = v && m_v && !(m_s && s);
         ec = m_c; es = m_s;
         if (v) begin m_v = 1'b1; m_c = c; m_s = s; end
      end
      #1;
      total++;
      if (out_valid !== ev || (ev && (out_char !== ec || out_is_sync !== es))) begin
         bad++;
         $display("FAIL %s: got v=%0b c=%02h s=%0b expected v=%0b c=%02h s=%0b",
                  req, out_valid, out_char, out_is_sync, ev, ec, es);
      end
   endtask

   task automatic t_reset_state();
      restart(2'b01);
      total++;
      if (out_valid !== 1'b0) begin
         bad++;
         $display("FAIL R7 reset: got out_valid=%0b expected 0", out_valid);
      end
   endtask

   task automatic t_pass_all();
      restart(2'b00);
      step(1, 8'h11, 0, "R1");
      step(1, 8'hBC, 1, "R1");
      step(1, 8'hBC, 1, "R1");
      step(0, 8'h00, 0, "R7");
      step(1, 8'h22, 0, "R1");
   endtask

   task automatic t_drop(input logic [1:0] pol);
      restart(pol);
      step(1, 8'h31, 0, "R2");
      step(1, 8'hBC, 1, "R2");
      step(1, 8'hBD, 1, "R2");
      step(1, 8'h32, 0, "R2");
      step(0, 8'h33, 0, "R7");
   endtask

   task automatic t_last_runs();
      restart(2'b01);
      step(1, 8'h41, 0, "R5");   // first input: nothing out
      step(1, 8'hB1, 1, "R5");   // releases 41
      step(1, 8'hB2, 1, "R3");   // B1 overwritten
      step(1, 8'hB3, 1, "R3");   // B2 overwritten
      step(1, 8'h42, 0, "R3");   // releases B3, last of run
      step(1, 8'hB4, 1, "R4");   // releases 42
      step(1, 8'h43, 0, "R4");   // releases lone B4
      step(1, 8'h44, 0, "R5");   // releases 43
   endtask

   task automatic t_last_idle();
      restart(2'b01);
      step(1, 8'h51, 0, "R5");
      step(1, 8'hC1, 1, "R5");   // 51 out
      step(0, 8'hEE, 1, "R9");   // idle with sync flag set: nothing
      step(0, 8'hEF, 0, "R9");
      step(1, 8'hC2, 1, "R9");   // C1 still held, overwritten
      step(0, 8'h00, 0, "R9");
      step(1, 8'h52, 0, "R9");   // releases C2
   endtask

   task automatic t_last_reset();
      restart(2'b01);
      step(1, 8'h61, 0, "R6");
      step(1, 8'hD1, 1, "R6");   // 61 out, D1 held
      restart(2'b01);            // D1 must be lost
      step(1, 8'h62, 0, "R6");   // nothing out
      step(1, 8'h63, 0, "R6");   // 62 out
   endtask

   initial begin
      #200000;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset_state();
      t_pass_all();
      t_drop(2'b10);
      t_drop(2'b11);
      t_last_runs();
      t_last_idle();
      t_last_reset();
      @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule